// File: doc/BRIEF.md
# Complex Quadratic Iteration Step

This block advances a complex point by one step of the recurrence z' = z*z + c. That recurrence is used to decide whether a point escapes. A caller gives the real and imaginary parts of z and c in signed Q4.12 fixed point, along with an iteration count, and pulses a start strobe. The block returns the new real and imaginary parts, the count plus one, and a flag. The flag shows whether the squared magnitude of the new point is still below 4.0. A one-cycle done strobe marks the moment these results appear.

Internally, one pipelined multiplier (latency 4) and one pipelined adder/subtractor (latency 3) are shared over time. A static schedule in a controller FSM picks the operands for each operator and enables the intermediate registers. Doubling is a one-cycle left shift by one bit. The final compare also takes one cycle. Products keep full precision and are then truncated toward minus infinity to Q4.12. Intermediate sums use a wider format so that they cannot overflow. The new z values are wrapped to 16 bits when they are captured.

Top module: `zstep_unit`

## Requirements
- R1: While reset is held and after it is released, every output is zero, including the done strobe.
- R2: The real result is ((x*x)>>>12) - ((y*y)>>>12) + cx, wrapped to a signed 16-bit Q4.12 value. Here >>> is an arithmetic shift of the full 32-bit product.
- R3: The imaginary result is 2*((x*y)>>>12) + cy, wrapped to a signed 16-bit Q4.12 value.
- R4: The bounded output is 1 exactly when ((zx'*zx')>>>12) + ((zy'*zy')>>>12) < 16384 (that is, 4.0), computed on the two 16-bit results.
- R5: The count output equals the 8-bit input count plus one, modulo 256.
- R6: Done is high for exactly one cycle. It rises 23 clock edges after the edge that accepts start.
- R7: A start raised while a computation is running is ignored: no extra done pulse occurs, and the running result is unchanged.
- R8: The result outputs keep their values from one done pulse until the next one, whatever the inputs do.
- R9: The data inputs are sampled only at the edge that accepts start. Changing them while the computation runs has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| zx_i | input | 16 | Real part of z, signed Q4.12 |
| zy_i | input | 16 | Imaginary part of z, signed Q4.12 |
| cx_i | input | 16 | Real part of c, signed Q4.12 |
| cy_i | input | 16 | Imaginary part of c, signed Q4.12 |
| cnt_i | input | 8 | Current iteration count |
| zx_o | output | 16 | Real part of the new z |
| zy_o | output | 16 | Imaginary part of the new z |
| bounded_o | output | 1 | Squared magnitude of the new z is below 4.0 |
| cnt_o | output | 8 | Incremented iteration count |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions check the following on every cycle:
- Each register capture coincides with a valid result leaving the shared operator it reads from.
- The controller advances one step per cycle once it has accepted start.
- Done never lasts two cycles.
- Outputs never move outside a done pulse.
- The count and the bounded flag agree with the values shown alongside them.

Only the bench scenarios can show the rest:
- the exact arithmetic, including truncation and wrap-around of large values;
- the 23-edge latency;
- the exact 4.0 boundary of the flag;
- the handling of a start raised mid-run;
- the handling of inputs that change mid-run.

// File: rtl/zstep_pkg.sv
package zstep_pkg;

    localparam int ZW      = 16;
    localparam int FRAC    = 12;
    localparam int CNT_W   = 8;
    localparam int MUL_LAT = 4;
    localparam int ADD_LAT = 3;
    localparam int DBL_LAT = 1;
    localparam int INT_W   = ZW - FRAC;
    localparam int AW      = 2 * INT_W + FRAC + 1;

    // static schedule, derived from operator latencies
    localparam int S_MXX   = 0;
    localparam int S_MYY   = 1;
    localparam int S_MXY   = 2;
    localparam int S_CXX   = S_MXX + MUL_LAT;
    localparam int S_CYY   = S_MYY + MUL_LAT;
    localparam int S_CXY   = S_MXY + MUL_LAT;
    localparam int S_ADIFF = S_CYY + 1;
    localparam int S_DBL   = S_CXY + 1;
    localparam int S_AIMAG = S_DBL + DBL_LAT;
    localparam int S_CDIFF = S_ADIFF + ADD_LAT;
    localparam int S_AREAL = S_CDIFF + 1;
    localparam int S_CIMAG = S_AIMAG + ADD_LAT;
    localparam int S_MNY   = S_CIMAG + 1;
    localparam int S_CREAL = S_AREAL + ADD_LAT;
    localparam int S_MNX   = S_CREAL + 1;
    localparam int S_CNY   = S_MNY + MUL_LAT;
    localparam int S_CNX   = S_MNX + MUL_LAT;
    localparam int S_AMAG  = S_CNX + 1;
    localparam int S_LAST  = S_AMAG + ADD_LAT;
    localparam int STEP_W  = $clog2(S_LAST + 1);

    typedef logic signed [ZW-1:0] zval_t;
    typedef logic signed [AW-1:0] acc_t;

    typedef enum logic {CS_IDLE, CS_RUN} cstate_e;
    typedef enum logic [2:0] {MOP_XX, MOP_YY, MOP_XY, MOP_NX2, MOP_NY2} mul_op_e;
    typedef enum logic [1:0] {AOP_DIFF, AOP_IMAG, AOP_REAL, AOP_MAG} add_op_e;

    typedef struct packed {
        logic    mul_go;
        mul_op_e mul_op;
        logic    add_go;
        add_op_e add_op;
        logic    ld_xx;
        logic    ld_yy;
        logic    ld_xy;
        logic    ld_dbl;
        logic    ld_diff;
        logic    ld_ny;
        logic    ld_nx;
        logic    ld_nyy;
        logic    ld_nxx;
        logic    ld_out;
    } ctl_t;

    localparam acc_t MAG_LIMIT = acc_t'(4 <<< FRAC);

    function automatic acc_t widen(input zval_t v);
        return acc_t'(v);
    endfunction

    function automatic zval_t narrow(input acc_t v);
        return v[ZW-1:0];
    endfunction

    function automatic acc_t prod_trunc(input zval_t a, input zval_t b);
        logic signed [2*ZW-1:0] p;
        p = a * b;
        return acc_t'(p >>> FRAC);
    endfunction

endpackage

// File: rtl/zstep_mul.sv
module zstep_mul
    import zstep_pkg::*;
#(
    parameter int LAT = MUL_LAT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  go_i,
    input  zval_t a_i,
    input  zval_t b_i,
    output acc_t  res_o,
    output logic  vld_o
);
    acc_t [LAT-1:0] pipe;
    logic [LAT-1:0] vld;

    always_ff @(posedge clk) begin
        pipe[0] <= prod_trunc(a_i, b_i);
        if (rst) vld[0] <= 1'b0;
        else     vld[0] <= go_i;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            pipe[i] <= pipe[i-1];
            if (rst) vld[i] <= 1'b0;
            else     vld[i] <= vld[i-1];
        end
    end

    assign res_o = pipe[LAT-1];
    assign vld_o = vld[LAT-1];
endmodule

// File: rtl/zstep_addsub.sv
module zstep_addsub
    import zstep_pkg::*;
#(
    parameter int LAT = ADD_LAT
) (
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic sub_i,
    input  acc_t a_i,
    input  acc_t b_i,
    output acc_t res_o,
    output logic vld_o
);
    acc_t [LAT-1:0] pipe;
    logic [LAT-1:0] vld;

    always_ff @(posedge clk) begin
        pipe[0] <= sub_i ? (a_i - b_i) : (a_i + b_i);
        if (rst) vld[0] <= 1'b0;
        else     vld[0] <= go_i;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            pipe[i] <= pipe[i-1];
            if (rst) vld[i] <= 1'b0;
            else     vld[i] <= vld[i-1];
        end
    end

    assign res_o = pipe[LAT-1];
    assign vld_o = vld[LAT-1];
endmodule

// File: rtl/zstep_ctrl.sv
module zstep_ctrl
    import zstep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic accept_o,
    output ctl_t ctl_o
);
    cstate_e           state;
    logic [STEP_W-1:0] step;

    function automatic logic at(input logic [STEP_W-1:0] s, input int k);
        return s == STEP_W'(k);
    endfunction

    assign accept_o = (state == CS_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_IDLE;
            step  <= '0;
        end else begin
            case (state)
                CS_IDLE: if (start_i) begin
                    state <= CS_RUN;
                    step  <= '0;
                end
                CS_RUN: if (at(step, S_LAST)) state <= CS_IDLE;
                        else                  step  <= step + 1'b1;
                default: state <= CS_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o = '0;
        ctl_o.mul_op = MOP_XX;
        ctl_o.add_op = AOP_DIFF;
        if (state == CS_RUN) begin
            if (at(step, S_MXX)) begin ctl_o.mul_go = 1'b1; ctl_o.mul_op = MOP_XX;  end
            if (at(step, S_MYY)) begin ctl_o.mul_go = 1'b1; ctl_o.mul_op = MOP_YY;  end
            if (at(step, S_MXY)) begin ctl_o.mul_go = 1'b1; ctl_o.mul_op = MOP_XY;  end
            if (at(step, S_MNY)) begin ctl_o.mul_go = 1'b1; ctl_o.mul_op = MOP_NY2; end
            if (at(step, S_MNX)) begin ctl_o.mul_go = 1'b1; ctl_o.mul_op = MOP_NX2; end
            if (at(step, S_ADIFF)) begin ctl_o.add_go = 1'b1; ctl_o.add_op = AOP_DIFF; end
            if (at(step, S_AIMAG)) begin ctl_o.add_go = 1'b1; ctl_o.add_op = AOP_IMAG; end
            if (at(step, S_AREAL)) begin ctl_o.add_go = 1'b1; ctl_o.add_op = AOP_REAL; end
            if (at(step, S_AMAG))  begin ctl_o.add_go = 1'b1; ctl_o.add_op = AOP_MAG;  end
            ctl_o.ld_xx   = at(step, S_CXX);
            ctl_o.ld_yy   = at(step, S_CYY);
            ctl_o.ld_xy   = at(step, S_CXY);
            ctl_o.ld_dbl  = at(step, S_DBL);
            ctl_o.ld_diff = at(step, S_CDIFF);
            ctl_o.ld_ny   = at(step, S_CIMAG);
            ctl_o.ld_nx   = at(step, S_CREAL);
            ctl_o.ld_nyy  = at(step, S_CNY);
            ctl_o.ld_nxx  = at(step, S_CNX);
            ctl_o.ld_out  = at(step, S_LAST);
        end
    end

    // R6: an accepted start begins the schedule at step zero
    p_start_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (state == CS_IDLE && start_i) |=> (state == CS_RUN && step == '0));

    // R7: a running schedule advances one step per cycle regardless of start
    p_run_advance_r7: assert property (@(posedge clk) disable iff (rst)
        (state == CS_RUN && !at(step, S_LAST)) |=> (state == CS_RUN && step == $past(step) + 1'b1));
endmodule

// File: rtl/zstep_unit.sv
module zstep_unit
    import zstep_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic signed [ZW-1:0]    zx_i,
    input  logic signed [ZW-1:0]    zy_i,
    input  logic signed [ZW-1:0]    cx_i,
    input  logic signed [ZW-1:0]    cy_i,
    input  logic [CNT_W-1:0]        cnt_i,
    output logic signed [ZW-1:0]    zx_o,
    output logic signed [ZW-1:0]    zy_o,
    output logic                    bounded_o,
    output logic [CNT_W-1:0]        cnt_o,
    output logic                    done_o
);
    ctl_t  ctl;
    logic  accept;
    zval_t rx, ry, rcx, rcy, nx_q, ny_q;
    logic [CNT_W-1:0] rcnt;
    acc_t  xx_q, yy_q, xy_q, dbl_q, diff_q, nxx_q, nyy_q;
    zval_t mul_a, mul_b;
    acc_t  add_a, add_b, mul_res, add_res;
    logic  add_sub, mul_vld, add_vld;

    zstep_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .accept_o(accept), .ctl_o(ctl)
    );

    always_comb begin
        case (ctl.mul_op)
            MOP_YY:  begin mul_a = ry;   mul_b = ry;   end
            MOP_XY:  begin mul_a = rx;   mul_b = ry;   end
            MOP_NX2: begin mul_a = nx_q; mul_b = nx_q; end
            MOP_NY2: begin mul_a = ny_q; mul_b = ny_q; end
            default: begin mul_a = rx;   mul_b = rx;   end
        endcase
    end

    always_comb begin
        add_sub = 1'b0;
        case (ctl.add_op)
            AOP_IMAG: begin add_a = dbl_q;  add_b = widen(rcy); end
            AOP_REAL: begin add_a = diff_q; add_b = widen(rcx); end
            AOP_MAG:  begin add_a = nxx_q;  add_b = nyy_q;      end
            default:  begin add_a = xx_q;   add_b = yy_q; add_sub = 1'b1; end
        endcase
    end

    zstep_mul #(.LAT(MUL_LAT)) u_mul (
        .clk(clk), .rst(rst), .go_i(ctl.mul_go), .a_i(mul_a), .b_i(mul_b),
        .res_o(mul_res), .vld_o(mul_vld)
    );

    zstep_addsub #(.LAT(ADD_LAT)) u_add (
        .clk(clk), .rst(rst), .go_i(ctl.add_go), .sub_i(add_sub),
        .a_i(add_a), .b_i(add_b), .res_o(add_res), .vld_o(add_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx <= '0; ry <= '0; rcx <= '0; rcy <= '0; rcnt <= '0;
            xx_q <= '0; yy_q <= '0; xy_q <= '0; dbl_q <= '0; diff_q <= '0;
            nxx_q <= '0; nyy_q <= '0; nx_q <= '0; ny_q <= '0;
            zx_o <= '0; zy_o <= '0; bounded_o <= 1'b0; cnt_o <= '0; done_o <= 1'b0;
        end else begin
            if (accept) begin
                rx <= zx_i; ry <= zy_i; rcx <= cx_i; rcy <= cy_i; rcnt <= cnt_i;
            end
            if (ctl.ld_xx)   xx_q   <= mul_res;
            if (ctl.ld_yy)   yy_q   <= mul_res;
            if (ctl.ld_xy)   xy_q   <= mul_res;
            if (ctl.ld_dbl)  dbl_q  <= xy_q <<< 1;
            if (ctl.ld_diff) diff_q <= add_res;
            if (ctl.ld_ny)   ny_q   <= narrow(add_res);
            if (ctl.ld_nx)   nx_q   <= narrow(add_res);
            if (ctl.ld_nyy)  nyy_q  <= mul_res;
            if (ctl.ld_nxx)  nxx_q  <= mul_res;
            done_o <= ctl.ld_out;
            if (ctl.ld_out) begin
                zx_o      <= nx_q;
                zy_o      <= ny_q;
                bounded_o <= (add_res < MAG_LIMIT);
                cnt_o     <= rcnt + 1'b1;
            end
        end
    end

    // R2: every product capture takes a valid multiplier result
    p_mul_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.ld_xx || ctl.ld_yy || ctl.ld_xy || ctl.ld_nxx || ctl.ld_nyy) |-> mul_vld);

    // R3: every sum capture and the final compare take a valid adder result
    p_add_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.ld_diff || ctl.ld_nx || ctl.ld_ny || ctl.ld_out) |-> add_vld);

    // R4: flag agrees with the results shown beside it
    p_bound_match_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (bounded_o == ((prod_trunc(zx_o, zx_o) + prod_trunc(zy_o, zy_o)) < MAG_LIMIT)));

    // R5: count output is the sampled count plus one
    p_count_inc_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cnt_o == CNT_W'(rcnt + 1'b1)));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: results only move together with a done pulse
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(zx_o) && $stable(zy_o) && $stable(bounded_o) && $stable(cnt_o)));
endmodule

// File: tb/zstep_unit_bench.sv
`timescale 1ns/1ps
module zstep_unit_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [15:0] zx_i = '0, zy_i = '0, cx_i = '0, cy_i = '0;
    logic [7:0] cnt_i = '0;
    logic signed [15:0] zx_o, zy_o;
    logic bounded_o, done_o;
    logic [7:0] cnt_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    zstep_unit u_zstep_unit (
        .clk(clk), .rst(rst), .start_i(start),
        .zx_i(zx_i), .zy_i(zy_i), .cx_i(cx_i), .cy_i(cy_i), .cnt_i(cnt_i),
        .zx_o(zx_o), .zy_o(zy_o), .bounded_o(bounded_o), .cnt_o(cnt_o), .done_o(done_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint tr(input longint a, input longint b);
        return (a * b) >>> 12;
    endfunction

    function automatic longint wrap16(input longint v);
        longint w;
        w = v & 64'hFFFF;
        if (w >= 32768) w = w - 65536;
        return w;
    endfunction

    // waits for done after start was accepted at the previous posedge; returns edge count
    task automatic wait_done(output int lat);
        lat = 0;
        while (!done_o && lat < 100) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
    endtask

    task automatic run_and_check(input string tag, input longint x, input longint y,
                                 input longint cx, input longint cy, input longint cnt);
        longint enx, eny, ebd;
        int lat;
        enx = wrap16(tr(x, x) - tr(y, y) + cx);
        eny = wrap16(2 * tr(x, y) + cy);
        ebd = (tr(enx, enx) + tr(eny, eny) < 16384) ? 1 : 0;
        @(negedge clk);
        zx_i = 16'(x); zy_i = 16'(y); cx_i = 16'(cx); cy_i = 16'(cy); cnt_i = 8'(cnt);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        check({tag, " R6 latency"}, lat, 23);
        check({tag, " R2 real"}, zx_o, enx);
        check({tag, " R3 imag"}, zy_o, eny);
        check({tag, " R4 bounded"}, bounded_o, ebd);
        check({tag, " R5 count"}, cnt_o, (cnt + 1) % 256);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R6 done single"}, done_o, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 zx", zx_o, 0);
        check("R1 zy", zy_o, 0);
        check("R1 bounded", bounded_o, 0);
        check("R1 cnt", cnt_o, 0);
        check("R1 done", done_o, 0);
    endtask

    task automatic t_zero;     run_and_check("zero", 0, 0, 0, 0, 0); endtask
    task automatic t_mixed;    run_and_check("mixed", 2048, -3072, -1024, 512, 7); endtask
    task automatic t_negative; run_and_check("neg", -6144, -5120, 1229, -2458, 254); endtask
    task automatic t_wrap;     run_and_check("wrap", 30720, 2048, 4096, -8192, 255); endtask

    task automatic t_boundary;
        run_and_check("edge_at4", 0, 0, 8192, 0, 3);
        run_and_check("edge_below4", 0, 0, 8191, 0, 3);
        run_and_check("edge_imag", 0, 0, 0, -8192, 9);
    endtask

    // R7 and R9: start and input changes during a run are ignored
    task automatic t_busy_start;
        longint x = 3000, y = -1500, cx = 700, cy = -300;
        longint enx, eny;
        int lat, pulses;
        enx = wrap16(tr(x, x) - tr(y, y) + cx);
        eny = wrap16(2 * tr(x, y) + cy);
        @(negedge clk);
        zx_i = 16'(x); zy_i = 16'(y); cx_i = 16'(cx); cy_i = 16'(cy); cnt_i = 8'd40;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        zx_i = -16'sd7000; zy_i = 16'sd5000; cx_i = 16'sd100; cy_i = 16'sd200; cnt_i = 8'd90;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done_o && lat < 100) begin @(posedge clk); lat++; @(negedge clk); end
        check("R7 first done", done_o, 1);
        check("R9 real", zx_o, enx);
        check("R9 imag", zy_o, eny);
        check("R7 count", cnt_o, 41);
        pulses = 0;
        repeat (30) begin
            @(posedge clk); @(negedge clk);
            if (done_o) pulses++;
        end
        check("R7 no extra done", pulses, 0);
    endtask

    // R8: outputs held between pulses while inputs move without start
    task automatic t_hold;
        logic signed [15:0] hx, hy;
        logic hb;
        logic [7:0] hc;
        hx = zx_o; hy = zy_o; hb = bounded_o; hc = cnt_o;
        @(negedge clk);
        zx_i = 16'sd1234; zy_i = -16'sd4321; cx_i = 16'sd99; cy_i = 16'sd77; cnt_i = 8'd5;
        repeat (12) @(negedge clk);
        check("R8 zx held", zx_o, hx);
        check("R8 zy held", zy_o, hy);
        check("R8 bounded held", bounded_o, hb);
        check("R8 cnt held", cnt_o, hc);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_zero();
        t_mixed();
        t_negative();
        t_wrap();
        t_boundary();
        t_busy_start();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule